// File: doc/BRIEF.md
# TDM audio serial transmitter

This block turns left-aligned 32-bit audio words, taken from a show-ahead transmit FIFO, into a single serial data stream with a matching frame sync. It runs in stereo mode, with two slots per frame, or in TDM mode with an even number of slots up to a build-time maximum. A separate bit-clock generator supplies `bclk_en`, a one-cycle pulse in the system clock domain. Every pulse moves the transmitter forward by one bit position.

The slot length (16 or 32 bit clocks) and the sample width (16, 24 or 32 bits) are set independently. A per-slot enable mask decides which slots take a word from the FIFO. The other slots send zeros. The protocol select chooses between I2S framing, where data trails the frame sync by one bit, and MSB-justified framing, where it does not. The frame can open with either a rising or a falling edge of the sync. The block also gives a FIFO refill request and a sticky underflow flag.

A small state machine controls the slots. `S_IDLE` holds the outputs quiet while `cfg_run` is low. On the first `bclk_en` after `cfg_run` rises, and again at the last bit of every slot, the machine picks the kind of slot that comes next. It goes to `S_DATA` when the slot is enabled and a word is present. It goes to `S_STARVED` when the slot is enabled but the FIFO is empty, and to `S_MUTE` when the slot is disabled. Dropping `cfg_run` returns the machine from any state to `S_IDLE` on the next clock.

Top module: `tdm_tx_serializer`

## Requirements
- R1: A slot lasts 16 bit clocks when `cfg_len32`=0 and 32 when it is 1. A frame is the effective slot count times that length, and frames follow one another with no gap.
- R2: Each slot sends its word MSB first, starting at bit 31. Only the top bits selected by `cfg_dsize` are sent (0 = 16, 1 = 24, 2 or 3 = 32). All later bit positions of the slot send 0. A 16-clock slot sends only the first 16 of those bits.
- R3: With `cfg_tdm`=0 the effective slot count is 2 whatever `cfg_slots` holds. With `cfg_tdm`=1 an odd `cfg_slots` is rounded up to the next even number, 0 counts as 2, and anything above MAX_SLOTS is limited to MAX_SLOTS.
- R4: Bit i of `cfg_slot_mask` enables slot i. An enabled slot pulls exactly one word, with a single `fifo_rd` cycle that coincides with the `bclk_en` that opens the slot. A disabled slot sends only zeros and pulls nothing. Mask bits at or above the effective slot count are ignored.
- R5: `fifo_req` is high exactly when `fifo_level` is below `cfg_thresh`.
- R6: With `cfg_fs_rising`=1, `fsync` is high during the first half of the slots of a frame and low during the second half. With 0 the levels are inverted. While idle, `fsync` rests at the second-half level.
- R7: With `cfg_i2s`=1, `sdata` carries the bit stream one bit clock after its frame position. With `cfg_i2s`=0 there is no delay.
- R8: If an enabled slot opens while the FIFO is empty, `underflow` goes high and stays high until reset. That slot sends zeros and pulls no word.
- R9: With `cfg_run` low, `sdata` is 0 and `fsync` is at its idle level from the next clock on. The first `bclk_en` after `cfg_run` rises places slot 0, bit 0 on the outputs.
- R10: While `cfg_run` is high, `sdata` and `fsync` change only on a clock edge at which `bclk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle pulse per bit clock |
| cfg_run | input | 1 | Transmitter enable |
| cfg_tdm | input | 1 | 1 = multi-slot frame, 0 = stereo |
| cfg_slots | input | CNT_W | Requested slots per frame (TDM only) |
| cfg_len32 | input | 1 | Slot length: 1 = 32 bit clocks, 0 = 16 |
| cfg_dsize | input | 2 | Sample width code: 0 = 16, 1 = 24, 2/3 = 32 |
| cfg_slot_mask | input | MAX_SLOTS | One enable bit per slot |
| cfg_i2s | input | 1 | 1 = one-bit data delay, 0 = MSB-justified |
| cfg_fs_rising | input | 1 | 1 = sync high in first half of frame |
| cfg_thresh | input | LVL_W | FIFO refill threshold (typical value 4) |
| fifo_data | input | 32 | Head word of the FIFO, left-aligned |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_level | input | LVL_W | FIFO fill level |
| fifo_rd | output | 1 | Pop strobe for the FIFO head |
| sdata | output | 1 | Serial data |
| fsync | output | 1 | Frame sync |
| underflow | output | 1 | Sticky starved-slot flag |
| fifo_req | output | 1 | FIFO below threshold |

## Verification
The properties assume three things about the inputs. The configuration is held steady while `cfg_run` is high. `fifo_data` is valid whenever `fifo_empty` is low. `bclk_en` is a single-cycle pulse. The bench keeps to all three: it changes configuration only while reset is held with the transmitter stopped, it models a show-ahead FIFO whose pointer moves on `fifo_rd`, and it fires `bclk_en` for one clock in every four. Within those limits it sweeps every combination of slot length, sample width and protocol in stereo mode. It then covers TDM frames with sparse masks, odd, zero and oversized slot counts, and a FIFO that runs dry part way through a frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int BIT_W    = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_DATA    = 2'd1,
        S_MUTE    = 2'd2,
        S_STARVED = 2'd3
    } tx_state_e;

    // Keep-mask for the valid top bits of a left-aligned word.
    function automatic logic [SAMPLE_W-1:0] width_keep(input logic [1:0] code);
        logic [SAMPLE_W-1:0] m;
        case (code)
            2'd0:    m = {{16{1'b1}}, {(SAMPLE_W-16){1'b0}}};
            2'd1:    m = {{24{1'b1}}, {(SAMPLE_W-24){1'b0}}};
            default: m = {SAMPLE_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tdm_tx_cfg_decode.sv
module tdm_tx_cfg_decode
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int CNT_W     = 4
) (
    input  logic                 cfg_tdm,
    input  logic [CNT_W-1:0]     cfg_slots,
    input  logic                 cfg_len32,
    input  logic [1:0]           cfg_dsize,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    output logic [CNT_W-1:0]     eff_slots,
    output logic [CNT_W-1:0]     half_slots,
    output logic [BIT_W-1:0]     last_bit,
    output logic [SAMPLE_W-1:0]  keep,
    output logic [MAX_SLOTS-1:0] slot_live
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] raw_cnt;
    logic [EXT_W-1:0] even_cnt;

    always_comb begin
        raw_cnt  = cfg_tdm ? {1'b0, cfg_slots} : EXT_W'(2);
        even_cnt = raw_cnt + {{CNT_W{1'b0}}, raw_cnt[0]};
        if (even_cnt == '0) begin
            eff_slots = CNT_W'(2);
        end else if (even_cnt > EXT_W'(MAX_SLOTS)) begin
            eff_slots = CNT_W'(MAX_SLOTS);
        end else begin
            eff_slots = even_cnt[CNT_W-1:0];
        end
    end

    assign half_slots = eff_slots >> 1;
    assign last_bit   = cfg_len32 ? BIT_W'(31) : BIT_W'(15);
    assign keep       = width_keep(cfg_dsize);

    for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_live
        assign slot_live[i] = cfg_slot_mask[i] && (CNT_W'(i) < eff_slots);
    end

endmodule

// File: rtl/tdm_tx_fifo_watch.sv
module tdm_tx_fifo_watch #(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             req
);

    assign req = (level < thresh);

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter
    import tdm_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                adv,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] load_word,
    input  logic                delay_en,
    output logic                sdata
);

    logic [SAMPLE_W-1:0] sh_q;
    logic                cur_q;
    logic                dly_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q  <= '0;
            cur_q <= 1'b0;
            dly_q <= 1'b0;
        end else if (adv) begin
            dly_q <= cur_q;
            if (load) begin
                cur_q <= load_word[SAMPLE_W-1];
                sh_q  <= {load_word[SAMPLE_W-2:0], 1'b0};
            end else begin
                cur_q <= sh_q[SAMPLE_W-1];
                sh_q  <= {sh_q[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    assign sdata = delay_en ? dly_q : cur_q;

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS  = 8,
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(MAX_SLOTS + 1),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_en,
    input  logic                 cfg_run,
    input  logic                 cfg_tdm,
    input  logic [CNT_W-1:0]     cfg_slots,
    input  logic                 cfg_len32,
    input  logic [1:0]           cfg_dsize,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic                 cfg_i2s,
    input  logic                 cfg_fs_rising,
    input  logic [LVL_W-1:0]     cfg_thresh,
    input  logic [31:0]          fifo_data,
    input  logic                 fifo_empty,
    input  logic [LVL_W-1:0]     fifo_level,
    output logic                 fifo_rd,
    output logic                 sdata,
    output logic                 fsync,
    output logic                 underflow,
    output logic                 fifo_req
);

    localparam int SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

    logic [CNT_W-1:0]     eff_slots;
    logic [CNT_W-1:0]     half_slots;
    logic [BIT_W-1:0]     last_bit;
    logic [SAMPLE_W-1:0]  keep;
    logic [MAX_SLOTS-1:0] slot_live;

    tdm_tx_cfg_decode #(
        .MAX_SLOTS(MAX_SLOTS),
        .CNT_W    (CNT_W)
    ) u_decode (
        .cfg_tdm      (cfg_tdm),
        .cfg_slots    (cfg_slots),
        .cfg_len32    (cfg_len32),
        .cfg_dsize    (cfg_dsize),
        .cfg_slot_mask(cfg_slot_mask),
        .eff_slots    (eff_slots),
        .half_slots   (half_slots),
        .last_bit     (last_bit),
        .keep         (keep),
        .slot_live    (slot_live)
    );

    tdm_tx_fifo_watch #(
        .LVL_W(LVL_W)
    ) u_watch (
        .level (fifo_level),
        .thresh(cfg_thresh),
        .req   (fifo_req)
    );

    tx_state_e        state_q, state_n;
    logic [CNT_W-1:0] slot_q, slot_n;
    logic [BIT_W-1:0] bit_q, bit_n;
    logic             slot_start;
    logic [CNT_W-1:0] start_slot;
    logic             sel_live;
    logic             pop;
    logic             starve;
    logic             adv;
    logic             clear;
    logic [SAMPLE_W-1:0] load_word;
    logic             fsync_q;
    logic             underflow_q;

    // Next-state and position logic
    always_comb begin
        state_n    = state_q;
        slot_n     = slot_q;
        bit_n      = bit_q;
        slot_start = 1'b0;
        start_slot = '0;
        if (!cfg_run) begin
            state_n = S_IDLE;
            slot_n  = '0;
            bit_n   = '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (bclk_en) begin
                        slot_start = 1'b1;
                        start_slot = '0;
                    end
                end
                S_DATA, S_MUTE, S_STARVED: begin
                    if (bclk_en) begin
                        if (bit_q == last_bit) begin
                            slot_start = 1'b1;
                            start_slot = (slot_q >= eff_slots - CNT_W'(1)) ? '0
                                                                           : slot_q + CNT_W'(1);
                        end else begin
                            bit_n = bit_q + BIT_W'(1);
                        end
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
        sel_live = slot_live[start_slot[SLOT_W-1:0]];
        if (slot_start) begin
            slot_n = start_slot;
            bit_n  = '0;
            if (!sel_live) begin
                state_n = S_MUTE;
            end else if (fifo_empty) begin
                state_n = S_STARVED;
            end else begin
                state_n = S_DATA;
            end
        end
    end

    assign pop       = slot_start && sel_live && !fifo_empty;
    assign starve    = slot_start && sel_live && fifo_empty;
    assign adv       = cfg_run && bclk_en;
    assign clear     = !cfg_run || ((state_q == S_IDLE) && !slot_start);
    assign load_word = pop ? (fifo_data & keep) : '0;
    assign fifo_rd   = pop;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slot_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_n;
            slot_q  <= slot_n;
            bit_q   <= bit_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync_q     <= 1'b0;
            underflow_q <= 1'b0;
        end else begin
            if (starve) begin
                underflow_q <= 1'b1;
            end
            if (!cfg_run) begin
                fsync_q <= ~cfg_fs_rising;
            end else if (slot_start) begin
                fsync_q <= (start_slot < half_slots) ^ ~cfg_fs_rising;
            end else if (state_q == S_IDLE) begin
                fsync_q <= ~cfg_fs_rising;
            end
        end
    end

    tdm_tx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .adv      (adv),
        .load     (slot_start),
        .load_word(load_word),
        .delay_en (cfg_i2s),
        .sdata    (sdata)
    );

    assign fsync     = fsync_q;
    assign underflow = underflow_q;

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic bclk_en,
    input logic cfg_run,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic sdata,
    input logic fsync,
    input logic underflow
);

    // R4: a pop only ever accompanies a bit-clock pulse
    p_pop_on_bclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> bclk_en);

    // R8: never pop an empty FIFO
    p_pop_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R8: underflow is sticky
    p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R9: stopped transmitter drives no data
    p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> !sdata);

    // R10: outputs hold between bit-clock pulses
    p_hold_between_bclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_en && cfg_run) |=> ($stable(sdata) && $stable(fsync)));

endmodule

bind tdm_tx_serializer tdm_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_en   (bclk_en),
    .cfg_run   (cfg_run),
    .fifo_empty(fifo_empty),
    .fifo_rd   (fifo_rd),
    .sdata     (sdata),
    .fsync     (fsync),
    .underflow (underflow)
);

// File: tb/tdm_tx_serializer_tb_top.sv
module tdm_tx_serializer_tb_top;

    localparam int MAX_SLOTS  = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = 4;
    localparam int LVL_W      = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n;
    logic                 bclk_en;
    logic                 cfg_run;
    logic                 cfg_tdm;
    logic [CNT_W-1:0]     cfg_slots;
    logic                 cfg_len32;
    logic [1:0]           cfg_dsize;
    logic [MAX_SLOTS-1:0] cfg_slot_mask;
    logic                 cfg_i2s;
    logic                 cfg_fs_rising;
    logic [LVL_W-1:0]     cfg_thresh;
    logic [31:0]          fifo_data;
    logic                 fifo_empty;
    logic [LVL_W-1:0]     fifo_level;
    logic                 fifo_rd;
    logic                 sdata;
    logic                 fsync;
    logic                 underflow;
    logic                 fifo_req;

    logic [31:0] mem [0:63];
    int          rdp;
    int          wrp;
    logic        fifo_clr;

    always @(posedge clk) begin
        if (fifo_clr) rdp <= 0;
        else if (fifo_rd) rdp <= rdp + 1;
    end

    assign fifo_data  = mem[rdp[5:0]];
    assign fifo_empty = (rdp >= wrp);
    assign fifo_level = LVL_W'(wrp - rdp);

    tdm_tx_serializer #(
        .MAX_SLOTS (MAX_SLOTS),
        .FIFO_DEPTH(FIFO_DEPTH)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_en      (bclk_en),
        .cfg_run      (cfg_run),
        .cfg_tdm      (cfg_tdm),
        .cfg_slots    (cfg_slots),
        .cfg_len32    (cfg_len32),
        .cfg_dsize    (cfg_dsize),
        .cfg_slot_mask(cfg_slot_mask),
        .cfg_i2s      (cfg_i2s),
        .cfg_fs_rising(cfg_fs_rising),
        .cfg_thresh   (cfg_thresh),
        .fifo_data    (fifo_data),
        .fifo_empty   (fifo_empty),
        .fifo_level   (fifo_level),
        .fifo_rd      (fifo_rd),
        .sdata        (sdata),
        .fsync        (fsync),
        .underflow    (underflow),
        .fifo_req     (fifo_req)
    );

    int n_checks = 0;
    int n_err    = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input int k);
        return 32'hA5C3_0F96 ^ (32'(k) * 32'h1357_9BDF);
    endfunction

    function automatic int eff_of(input int tdm, input int slots);
        int r;
        r = (tdm != 0) ? slots : 2;
        if (r % 2 == 1) r++;
        if (r == 0) r = 2;
        if (r > MAX_SLOTS) r = MAX_SLOTS;
        return r;
    endfunction

    function automatic int bits_below(input int mask, input int lim);
        int c = 0;
        for (int i = 0; i < lim; i++) if (mask[i]) c++;
        return c;
    endfunction

    // Expected undelayed stream bit at position n
    function automatic logic msb_exp(input int n, input int eff, input int len, input int dsz,
                                     input int mask, input int loaded);
        int fl, fr, r, s, b, k;
        logic [31:0] w;
        if (n < 0) return 1'b0;
        fl = eff * len;
        fr = n / fl;
        r  = n % fl;
        s  = r / len;
        b  = r % len;
        if (!mask[s]) return 1'b0;
        k = fr * bits_below(mask, eff) + bits_below(mask, s);
        if (k >= loaded) return 1'b0;
        if (b >= dsz) return 1'b0;
        w = word_of(k);
        return w[31-b];
    endfunction

    task automatic do_reset(input int loaded);
        rst_n    = 1'b0;
        cfg_run  = 1'b0;
        bclk_en  = 1'b0;
        fifo_clr = 1'b1;
        wrp      = loaded;
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        fifo_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_cfg(input string tag, input int tdm, input int slots, input int len32,
                           input int dsize, input int mask, input int i2s, input int rising,
                           input int loaded, input int frames);
        int eff, len, dsz, en_cnt, total, pops;
        logic xs, xf;
        cfg_tdm       = tdm[0];
        cfg_slots     = CNT_W'(slots);
        cfg_len32     = len32[0];
        cfg_dsize     = 2'(dsize);
        cfg_slot_mask = MAX_SLOTS'(mask);
        cfg_i2s       = i2s[0];
        cfg_fs_rising = rising[0];
        do_reset(loaded);
        eff    = eff_of(tdm, slots);
        len    = (len32 != 0) ? 32 : 16;
        dsz    = (dsize == 0) ? 16 : (dsize == 1) ? 24 : 32;
        en_cnt = bits_below(mask, eff);
        total  = frames * eff * len;
        pops   = (loaded < frames * en_cnt) ? loaded : frames * en_cnt;
        check({"R6 idle sync ", tag}, 32'(fsync), 32'(rising == 0));
        check({"R8 clear after reset ", tag}, 32'(underflow), 32'd0);
        cfg_run = 1'b1;
        @(negedge clk);
        for (int n = 0; n < total; n++) begin
            bclk_en = 1'b1;
            @(negedge clk);
            bclk_en = 1'b0;
            xs = (i2s != 0) ? msb_exp(n - 1, eff, len, dsz, mask, loaded)
                            : msb_exp(n, eff, len, dsz, mask, loaded);
            xf = (((n % (eff * len)) / len) < (eff / 2)) ^ (rising == 0);
            check({(i2s != 0) ? "R7 delayed data " : "R2 data ", tag}, 32'(sdata), 32'(xs));
            check({"R1/R6 sync ", tag}, 32'(fsync), 32'(xf));
            @(negedge clk);
            check({"R10 hold ", tag}, {30'd0, sdata, fsync}, {30'd0, xs, xf});
            repeat (2) @(negedge clk);
        end
        check({"R3/R4 words pulled ", tag}, 32'(rdp), 32'(pops));
        check({"R8 flag ", tag}, 32'(underflow), 32'(loaded < frames * en_cnt));
        cfg_run = 1'b0;
        repeat (2) @(negedge clk);
        check({"R9 stopped data ", tag}, 32'(sdata), 32'd0);
        check({"R9 stopped sync ", tag}, 32'(fsync), 32'(rising == 0));
    endtask

    initial begin
        rst_n = 1'b0;
        bclk_en = 1'b0;
        cfg_run = 1'b0;
        cfg_tdm = 1'b0;
        cfg_slots = '0;
        cfg_len32 = 1'b1;
        cfg_dsize = 2'd2;
        cfg_slot_mask = 8'h03;
        cfg_i2s = 1'b0;
        cfg_fs_rising = 1'b1;
        cfg_thresh = LVL_W'(4);
        fifo_clr = 1'b1;
        wrp = 0;
        for (int k = 0; k < 64; k++) mem[k] = word_of(k);
        do_reset(0);
        check("R9 reset data", 32'(sdata), 32'd0);
        check("R6 reset sync", 32'(fsync), 32'd0);
        check("R8 reset flag", 32'(underflow), 32'd0);
        check("R4 reset pop", 32'(fifo_rd), 32'd0);

        // R5: refill request against two thresholds
        for (int t = 4; t <= 6; t += 2) begin
            cfg_thresh = LVL_W'(t);
            for (int lv = 0; lv <= 8; lv++) begin
                wrp = lv;
                @(negedge clk);
                check("R5 request", 32'(fifo_req), 32'(lv < t));
            end
        end

        // Stereo sweep over slot length, sample width and protocol
        for (int l = 0; l < 2; l++)
            for (int d = 0; d < 3; d++)
                for (int p = 0; p < 2; p++)
                    run_cfg("stereo sweep", 0, 2, l, d, 3, p, (d + l) % 2, 4, 2);

        run_cfg("tdm8 sparse R4", 1, 8, 1, 2, 8'b1011_0101, 0, 1, 16, 2);
        run_cfg("tdm4 short slot R2", 1, 4, 0, 2, 8'hFF, 1, 0, 16, 2);
        run_cfg("tdm odd count R3", 1, 5, 0, 1, 8'h3F, 0, 1, 16, 2);
        run_cfg("tdm oversized R3", 1, 12, 0, 0, 8'h81, 1, 1, 16, 2);
        run_cfg("tdm zero count R3", 1, 0, 0, 2, 8'hFF, 0, 0, 16, 2);
        run_cfg("stereo ignores count R3", 0, 8, 0, 2, 8'hFF, 0, 1, 8, 2);
        run_cfg("starved R8", 1, 4, 0, 1, 8'h05, 1, 1, 3, 2);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule